// File: doc/BRIEF.md
# Load/Store Decode and Byte-Lane Steering

This block sits between the register file and the data port of a 32-bit big-endian core. From one instruction word and the register values it decides whether the word is a load, a store or something it does not recognise. It forms the effective address and drives byte enables, write data and a write strobe toward memory. For loads, it pulls the addressed byte, halfword or word out of the memory read word and zero-extends it into a register value. The instruction numbers its bits from 0 at the most significant end. In little-index terms the opcode is instr[31:26], the destination or source register index is instr[25:21], Ra is instr[20:16], Rb is instr[15:11], the function field is instr[10:0] and the immediate is instr[15:0].

The block is purely combinational. Every output follows its inputs within the same cycle. Exclusive-store reservation tracking, alignment traps and the memory itself belong to the surrounding logic. For an exclusive store the block only raises a marker, and that logic decides whether the write is allowed to land.

Top module: `lsu_lane_steer`

## Requirements
- R1: The effective address mem_addr is Ra plus the sign-extended instr[15:0] when the opcode's upper three bits are 111, and Ra plus Rb otherwise, wrapping modulo 2^32.
- R2: The recognised words are as follows. Opcode 6'h35 or 6'h36 with function 11'h000 or 11'h200 is recognised, and opcode 6'h36 with function 11'h400 is also recognised. Opcodes 6'h38, 6'h39, 6'h3A, 6'h3C, 6'h3D and 6'h3E are recognised with any low bits. Any other word sets illegal and forces mem_we, mem_be, mem_excl, ld_en, mem_wdata and ld_data to zero.
- R3: Lane order is big-endian. mem_be[3] and data bits 31:24 are address offset 0, and mem_be[0] and bits 7:0 are offset 3. Byte accesses use addr[1:0]. Halfword accesses use addr[1] only, giving 4'b1100 or 4'b0011. Word accesses use 4'b1111. Address bits below the access size are ignored.
- R4: A byte store (6'h3C) raises mem_we and places Rd[7:0] in all four lanes of mem_wdata.
- R5: A halfword store (6'h35 with function 11'h000, or 6'h3D) raises mem_we and places Rd[15:0] in both halves of mem_wdata.
- R6: The reversed stores (function 11'h200) swap the byte order of the stored unit. On 6'h35 this gives {Rd[7:0],Rd[15:8]} in both halves. On 6'h36 this gives {Rd[7:0],Rd[15:8],Rd[23:16],Rd[31:24]}.
- R7: A word store (6'h36 with function 11'h000, or 6'h3E) raises mem_we and drives mem_wdata equal to Rd.
- R8: The exclusive store (6'h36 with function 11'h400) behaves as a word store and also raises mem_excl. mem_excl is zero for every other word.
- R9: A byte load (6'h38) raises ld_en, keeps mem_we low, and returns the addressed byte in ld_data[7:0] with bits 31:8 zero.
- R10: A halfword load (6'h39) returns the addressed halfword in ld_data[15:0] with bits 31:16 zero.
- R11: A word load (6'h3A) returns mem_rdata unchanged. ld_data is zero whenever ld_en is low, and mem_wdata is zero whenever mem_we is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word, bit 31 = architectural bit 0 |
| ra_val | input | 32 | Value of base register Ra |
| rb_val | input | 32 | Value of index register Rb |
| rd_val | input | 32 | Value of register Rd (store source) |
| mem_rdata | input | 32 | Memory read word, bits 31:24 = offset 0 |
| mem_addr | output | 32 | Effective address |
| mem_be | output | 4 | Byte enables, bit 3 = offset 0 |
| mem_wdata | output | 32 | Lane-steered store data |
| mem_we | output | 1 | Write strobe |
| mem_excl | output | 1 | Store is exclusive and awaits reservation check |
| ld_en | output | 1 | Word is a load and ld_data is valid |
| ld_data | output | 32 | Zero-extended loaded register value |
| illegal | output | 1 | Word not recognised as a load or store |

## Verification
Because nothing is stored, a bad decode or lane choice appears at the ports in the same cycle as the instruction that provokes it. A wrong size decode shows up as an enable pattern with the wrong number of lanes, or as stray upper bits in a loaded value. A wrong lane offset moves the enable bit and selects the wrong byte of the read word. A missed function-field check shows up as a write strobe on a word that should be flagged illegal. The bench compares every output against a byte-by-byte model after each stimulus, so any of these faults is reported on the first instruction that reaches the broken path.

// File: rtl/lsu_lane_steer.sv
module lsu_lane_steer (
  input  logic [31:0] instr,
  input  logic [31:0] ra_val,
  input  logic [31:0] rb_val,
  input  logic [31:0] rd_val,
  input  logic [31:0] mem_rdata,
  output logic [31:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  output logic        mem_we,
  output logic        mem_excl,
  output logic        ld_en,
  output logic [31:0] ld_data,
  output logic        illegal
);
  localparam logic [5:0]  OP_HALF_RR = 6'h35;
  localparam logic [5:0]  OP_WORD_RR = 6'h36;
  localparam logic [5:0]  OP_LDB_I   = 6'h38;
  localparam logic [5:0]  OP_LDH_I   = 6'h39;
  localparam logic [5:0]  OP_LDW_I   = 6'h3A;
  localparam logic [5:0]  OP_STB_I   = 6'h3C;
  localparam logic [5:0]  OP_STH_I   = 6'h3D;
  localparam logic [5:0]  OP_STW_I   = 6'h3E;
  localparam logic [10:0] FN_PLAIN   = 11'h000;
  localparam logic [10:0] FN_SWAP    = 11'h200;
  localparam logic [10:0] FN_EXCL    = 11'h400;
  localparam logic [1:0]  SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2;

  wire [5:0]  op = instr[31:26];
  wire [10:0] fn = instr[10:0];

  logic       is_st, is_ld, swap, xcl;
  logic [1:0] sz;

  always_comb begin
    is_st = 1'b0;
    is_ld = 1'b0;
    swap  = 1'b0;
    xcl   = 1'b0;
    sz    = SZ_W;
    case (op)
      OP_HALF_RR: begin
        sz = SZ_H;
        if (fn == FN_PLAIN) is_st = 1'b1;
        else if (fn == FN_SWAP) begin is_st = 1'b1; swap = 1'b1; end
      end
      OP_WORD_RR: begin
        if (fn == FN_PLAIN) is_st = 1'b1;
        else if (fn == FN_SWAP) begin is_st = 1'b1; swap = 1'b1; end
        else if (fn == FN_EXCL) begin is_st = 1'b1; xcl = 1'b1; end
      end
      OP_LDB_I: begin is_ld = 1'b1; sz = SZ_B; end
      OP_LDH_I: begin is_ld = 1'b1; sz = SZ_H; end
      OP_LDW_I: is_ld = 1'b1;
      OP_STB_I: begin is_st = 1'b1; sz = SZ_B; end
      OP_STH_I: begin is_st = 1'b1; sz = SZ_H; end
      OP_STW_I: is_st = 1'b1;
      default: ;
    endcase
  end

  wire        imm_form = (op[5:3] == 3'b111);
  wire [31:0] offset_v = imm_form ? {{16{instr[15]}}, instr[15:0]} : rb_val;
  assign mem_addr = ra_val + offset_v;

  wire [1:0] lane = (sz == SZ_B) ? mem_addr[1:0] :
                    (sz == SZ_H) ? {mem_addr[1], 1'b0} : 2'b00;

  wire [3:0] be_unit = (sz == SZ_B) ? (4'b1000 >> lane) :
                       (sz == SZ_H) ? (4'b1100 >> lane) : 4'b1111;

  wire [15:0] half_src = swap ? {rd_val[7:0], rd_val[15:8]} : rd_val[15:0];
  wire [31:0] word_src = swap ? {rd_val[7:0], rd_val[15:8], rd_val[23:16], rd_val[31:24]}
                              : rd_val;

  wire [31:0] rd_shift = mem_rdata << {lane, 3'b000};

  assign illegal  = !(is_st || is_ld);
  assign mem_we   = is_st;
  assign mem_excl = is_st && xcl;
  assign ld_en    = is_ld;
  assign mem_be   = illegal ? 4'b0000 : be_unit;

  assign mem_wdata = !is_st       ? 32'h0 :
                     (sz == SZ_B) ? {4{rd_val[7:0]}} :
                     (sz == SZ_H) ? {2{half_src}} : word_src;

  assign ld_data = !is_ld       ? 32'h0 :
                   (sz == SZ_B) ? {24'h0, rd_shift[31:24]} :
                   (sz == SZ_H) ? {16'h0, rd_shift[31:16]} : mem_rdata;
endmodule

module lsu_lane_steer_chk (
  input logic [31:0] instr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        mem_we,
  input logic        mem_excl,
  input logic        ld_en,
  input logic [31:0] ld_data,
  input logic        illegal
);
  always_comb begin
    if (!$isunknown({instr, mem_be, mem_we, mem_excl, ld_en, illegal, ld_data, mem_wdata})) begin
      a_r2_illegal_quiet: assert (!illegal || (!mem_we && !ld_en && !mem_excl && mem_be == 4'b0000))
        else $error("illegal word produced an access");
      a_r2_kind_exclusive: assert ($onehot({mem_we, ld_en, illegal}))
        else $error("access kind not exactly one");
      a_r3_be_size: assert (illegal || $countones(mem_be) == 1 || mem_be == 4'b1100 ||
                            mem_be == 4'b0011 || mem_be == 4'b1111)
        else $error("byte enable pattern malformed");
      a_r8_excl_word: assert (!mem_excl || (mem_we && mem_be == 4'b1111))
        else $error("exclusive marker on non-word store");
      a_r9_byte_zext: assert (!(ld_en && $countones(mem_be) == 1) || ld_data[31:8] == 24'h0)
        else $error("byte load not zero-extended");
      a_r10_half_zext: assert (!(ld_en && $countones(mem_be) == 2) || ld_data[31:16] == 16'h0)
        else $error("halfword load not zero-extended");
      a_r11_idle_zero: assert ((ld_en || ld_data == 32'h0) && (mem_we || mem_wdata == 32'h0))
        else $error("inactive data path not zero");
    end
  end
endmodule

bind lsu_lane_steer lsu_lane_steer_chk i_chk (
  .instr(instr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_we(mem_we),
  .mem_excl(mem_excl), .ld_en(ld_en), .ld_data(ld_data), .illegal(illegal)
);

// File: tb/test_lsu_lane_steer.sv
module test_lsu_lane_steer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] instr, ra_val, rb_val, rd_val, mem_rdata;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  logic [3:0]  mem_be;
  logic        mem_we, mem_excl, ld_en, illegal;

  int checks = 0;
  int errs = 0;
  bit done = 0;

  lsu_lane_steer i_lsu_lane_steer (
    .instr(instr), .ra_val(ra_val), .rb_val(rb_val), .rd_val(rd_val),
    .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_excl(mem_excl),
    .ld_en(ld_en), .ld_data(ld_data), .illegal(illegal)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h (instr=%h)", tag, act, exp, instr);
    end
  endtask

  // reference model, byte by byte
  task automatic check_all();
    logic [5:0]  op;
    logic [10:0] fn;
    int          n;
    bit          st, ld, rev, xc;
    string       tg;
    logic [31:0] a, ew, el;
    logic [3:0]  eb;
    logic [7:0]  ub[4];
    int          o;
    op = instr[31:26]; fn = instr[10:0];
    st = 0; ld = 0; rev = 0; xc = 0; n = 4; tg = "R2";
    if (op == 6'h35 && (fn == 11'h000 || fn == 11'h200)) begin
      st = 1; n = 2; rev = (fn == 11'h200); tg = rev ? "R6" : "R5";
    end else if (op == 6'h36 && (fn == 11'h000 || fn == 11'h200 || fn == 11'h400)) begin
      st = 1; rev = (fn == 11'h200); xc = (fn == 11'h400);
      tg = xc ? "R8" : (rev ? "R6" : "R7");
    end else if (op == 6'h38) begin ld = 1; n = 1; tg = "R9"; end
    else if (op == 6'h39) begin ld = 1; n = 2; tg = "R10"; end
    else if (op == 6'h3A) begin ld = 1; tg = "R11"; end
    else if (op == 6'h3C) begin st = 1; n = 1; tg = "R4"; end
    else if (op == 6'h3D) begin st = 1; n = 2; tg = "R5"; end
    else if (op == 6'h3E) begin st = 1; tg = "R7"; end

    a = ra_val + ((op >= 6'h38) ? {{16{instr[15]}}, instr[15:0]} : rb_val);
    o = (n == 4) ? 0 : (n == 2) ? {a[1], 1'b0} : int'(a[1:0]);
    eb = 4'b0; ew = 32'h0; el = 32'h0;
    for (int k = 0; k < n; k++) begin
      ub[k] = rev ? rd_val[8*k +: 8] : rd_val[8*(n-1-k) +: 8];
      if (st || ld) eb[3-(o+k)] = 1'b1;
      if (ld) el[8*(n-1-k) +: 8] = mem_rdata[31-8*(o+k) -: 8];
    end
    if (st) for (int l = 0; l < 4; l++) ew[31-8*l -: 8] = ub[l % n];

    chk("R1 addr", mem_addr, a);
    chk({"R3 be ", tg}, {28'h0, mem_be}, {28'h0, eb});
    chk({tg, " we"}, {31'h0, mem_we}, {31'h0, st});
    chk({tg, " wdata"}, mem_wdata, ew);
    chk({"R8 excl ", tg}, {31'h0, mem_excl}, {31'h0, xc});
    chk({tg, " ld_en"}, {31'h0, ld_en}, {31'h0, ld});
    chk({tg, " ld_data"}, ld_data, el);
    chk({"R2 illegal ", tg}, {31'h0, illegal}, {31'h0, !(st || ld)});
  endtask

  task automatic apply(input logic [31:0] i, a, b, d, r);
    @(negedge clk);
    instr = i; ra_val = a; rb_val = b; rd_val = d; mem_rdata = r;
    #2 check_all();
  endtask

  function automatic logic [31:0] rr(input logic [5:0] op, input logic [10:0] fn);
    return {op, 5'd3, 5'd4, 5'd5, fn};
  endfunction
  function automatic logic [31:0] ri(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'd3, 5'd4, imm};
  endfunction

  initial begin
    #2000000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] tmpl [12];
    void'($urandom(32'h5EED_1234));
    // idle word: opcode 0 is illegal (R2)
    apply(32'h0, 32'h0, 32'h0, 32'h0, 32'h0);
    // R1 wrap and negative immediate
    apply(ri(6'h3A, 16'hFFFC), 32'h0000_0002, 32'h0, 32'h0, 32'hA1B2C3D4);
    apply(rr(6'h36, 11'h000), 32'hFFFF_FFFF, 32'h0000_0005, 32'h11223344, 32'h0);
    // R3 byte lanes at every offset, R9 extraction
    for (int k = 0; k < 4; k++) apply(ri(6'h38, 16'(k)), 32'h100, 32'h0, 32'h0, 32'h8899AABB);
    for (int k = 0; k < 4; k++) apply(ri(6'h3C, 16'(k)), 32'h100, 32'h0, 32'hDEADBE5A, 32'h0);
    // R10 and R5/R6 at both halves, odd low bit ignored
    apply(ri(6'h39, 16'h0003), 32'h200, 32'h0, 32'h0, 32'hFEDC1234);
    apply(rr(6'h35, 11'h200), 32'h201, 32'h0, 32'h0000A1B2, 32'h0);
    apply(rr(6'h36, 11'h200), 32'h40, 32'h0, 32'h01020304, 32'h0);
    // R8 exclusive store
    apply(rr(6'h36, 11'h400), 32'h40, 32'h4, 32'hCAFEF00D, 32'h0);
    // R2 near-miss function fields
    apply(rr(6'h36, 11'h001), 32'h40, 32'h4, 32'hCAFEF00D, 32'h0);
    apply(rr(6'h35, 11'h400), 32'h40, 32'h4, 32'hCAFEF00D, 32'h0);
    apply(ri(6'h3B, 16'h0), 32'h40, 32'h4, 32'hCAFEF00D, 32'h0);

    tmpl[0] = rr(6'h35, 11'h000); tmpl[1] = rr(6'h35, 11'h200);
    tmpl[2] = rr(6'h36, 11'h000); tmpl[3] = rr(6'h36, 11'h200);
    tmpl[4] = rr(6'h36, 11'h400); tmpl[5] = ri(6'h38, 0);
    tmpl[6] = ri(6'h39, 0);       tmpl[7] = ri(6'h3A, 0);
    tmpl[8] = ri(6'h3C, 0);       tmpl[9] = ri(6'h3D, 0);
    tmpl[10] = ri(6'h3E, 0);      tmpl[11] = 32'h0;
    for (int i = 0; i < 3000; i++) begin
      int sel;
      logic [31:0] w;
      sel = int'($urandom_range(0, 12));
      if (sel == 12) w = $urandom();
      else if (tmpl[sel][31:26] >= 6'h38) w = {tmpl[sel][31:16], 16'($urandom())};
      else if (sel == 11) w = $urandom();
      else w = {tmpl[sel][31:26], 15'($urandom()), tmpl[sel][10:0]};
      apply(w, $urandom(), $urandom(), $urandom(), $urandom());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule